// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card clock from the fast core clock. A divisor register holds the division ratio minus two. The card clock period is therefore (divisor + 2) core cycles, so a divisor of zero yields half the core rate. A mode input selects how the divisor is applied. In identification mode the full divisor is used. In data mode only its low three bits are used, unless a slow-card configuration bit is set, which keeps the full divisor in force in both modes.

The clock never stops. The slowest rate comes from the largest divisor. Alongside the card clock, the block emits two single-cycle strobes aligned with its rising and falling edges, which the command and data shift registers use as enables. Divisor writes and mode changes are held off until the running card clock period ends, so no shortened pulse reaches the card.

Top module: `sd_clk_divider`

## Requirements
- R1: After reset the divisor is 507 and the slow-card bit is clear. During reset the card clock and both strobes are low. On the first core clock edge after reset is released, a card clock period of 509 cycles starts, assuming identification mode.
- R2: In identification mode (data_mode_i = 0) the card clock period is (divisor + 2) core cycles.
- R3: Each period is high for ceil(P/2) core cycles and then low for floor(P/2) core cycles, where P is the period length.
- R4: In data mode (data_mode_i = 1) with the slow-card bit clear, the period is (divisor[2:0] + 2) core cycles, and divisor bits 10..3 are ignored.
- R5: With the slow-card bit set, the period is (divisor + 2) core cycles in data mode as well.
- R6: A divisor written during a card clock period does not change that period. The new divisor takes effect with the next period.
- R7: clk_rise_o is high for exactly the first core cycle of each high phase. clk_fall_o is high for exactly the first core cycle of each low phase. Each strobe occurs once per period, and the two are never high together.
- R8: A divisor of 0x7FF gives the slowest period, 2049 core cycles. A divisor of 0 gives 2 core cycles.
- R9: A change of data_mode_i applies from the next period boundary. The period in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_we_i | input | 1 | Divisor write enable |
| div_wdata_i | input | 11 | Divisor value (ratio minus two) |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_slow_i | input | 1 | Slow-card bit value written with cfg_we_i |
| data_mode_i | input | 1 | 0 = identification mode, 1 = data mode |
| sd_clk_o | output | 1 | Card clock |
| clk_rise_o | output | 1 | Strobe for the first cycle of each high phase |
| clk_fall_o | output | 1 | Strobe for the first cycle of each low phase |

## Verification
The bench uses the default parameters: an 11-bit divisor, a 3-bit data-mode field and a reset divisor of 507. With an 11-bit divisor the slowest period, 2049 cycles, is short enough to measure in full. This covers both ends of the divisor range, the masking of the data-mode field, and the 509-cycle period after reset. Odd and even period lengths test the uneven split between high and low phases. Writes and mode changes issued just after a rising edge test that the period in progress is not cut short.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int unsigned DivW     = 11;
  localparam int unsigned DataBits = 3;
  localparam int unsigned RstDiv   = 507;
endpackage

// File: rtl/sdclk_div_reg.sv
module sdclk_div_reg #(
  parameter int unsigned DIV_W   = 11,
  parameter int unsigned RST_DIV = 507
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             cfg_we_i,
  input  logic             cfg_slow_i,
  output logic [DIV_W-1:0] div_o,
  output logic             slow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= DIV_W'(RST_DIV);
      slow_o <= 1'b0;
    end else begin
      if (div_we_i) div_o  <= div_wdata_i;
      if (cfg_we_i) slow_o <= cfg_slow_i;
    end
  end

  p_div_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_we_i |=> $stable(div_o));
endmodule

// File: rtl/sdclk_ratio_sel.sv
module sdclk_ratio_sel #(
  parameter int unsigned DIV_W     = 11,
  parameter int unsigned DATA_BITS = 3,
  localparam int unsigned RATIO_W  = DIV_W + 1
) (
  input  logic [DIV_W-1:0]   div_i,
  input  logic               slow_i,
  input  logic               data_mode_i,
  output logic [RATIO_W-1:0] ratio_o
);
  logic [DIV_W-1:0] data_div;

  generate
    if (DATA_BITS >= DIV_W) begin : g_full
      assign data_div = div_i;
    end else begin : g_trunc
      assign data_div = {{(DIV_W-DATA_BITS){1'b0}}, div_i[DATA_BITS-1:0]};
    end
  endgenerate

  always_comb begin
    if (data_mode_i && !slow_i) ratio_o = RATIO_W'(data_div) + RATIO_W'(2);
    else                        ratio_o = RATIO_W'(div_i) + RATIO_W'(2);
  end

  always_comb begin
    p_data_cap_r4: assert (!(data_mode_i && !slow_i) ||
                           (32'(ratio_o) <= (32'd1 << DATA_BITS) + 32'd1));
  end
endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen #(
  parameter int unsigned RATIO_W   = 12,
  parameter int unsigned RST_RATIO = 509
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               sd_clk_o,
  output logic               rise_o,
  output logic               fall_o
);
  logic [RATIO_W-1:0] cnt_q, cnt_d, ratio_q, ratio_d, hi_d;
  logic               wrap;

  assign wrap    = (cnt_q == ratio_q - RATIO_W'(1));
  assign cnt_d   = wrap ? '0 : cnt_q + RATIO_W'(1);
  assign ratio_d = wrap ? ratio_i : ratio_q;
  assign hi_d    = (ratio_d + RATIO_W'(1)) >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q  <= RATIO_W'(RST_RATIO);
      cnt_q    <= RATIO_W'(RST_RATIO - 1);
      sd_clk_o <= 1'b0;
      rise_o   <= 1'b0;
      fall_o   <= 1'b0;
    end else begin
      ratio_q  <= ratio_d;
      cnt_q    <= cnt_d;
      sd_clk_o <= (cnt_d < hi_d);
      rise_o   <= (cnt_d == '0);
      fall_o   <= (cnt_d == hi_d);
    end
  end

  p_rise_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sd_clk_o) |-> rise_o);
  p_fall_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sd_clk_o) |-> fall_o);
  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
  p_ratio_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable(ratio_q));
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_q);
  p_min_ratio_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_q >= RATIO_W'(2));
endmodule

// File: rtl/sd_clk_divider.sv
module sd_clk_divider #(
  parameter int unsigned DIV_W     = sdclk_pkg::DivW,
  parameter int unsigned DATA_BITS = sdclk_pkg::DataBits,
  parameter int unsigned RST_DIV   = sdclk_pkg::RstDiv
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             cfg_we_i,
  input  logic             cfg_slow_i,
  input  logic             data_mode_i,
  output logic             sd_clk_o,
  output logic             clk_rise_o,
  output logic             clk_fall_o
);
  localparam int unsigned RatioW   = DIV_W + 1;
  localparam int unsigned RstRatio = RST_DIV + 2;

  logic [DIV_W-1:0]  div_q;
  logic              slow_q;
  logic [RatioW-1:0] ratio;

  sdclk_div_reg #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_we_i    (div_we_i),
    .div_wdata_i (div_wdata_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_slow_i  (cfg_slow_i),
    .div_o       (div_q),
    .slow_o      (slow_q)
  );

  sdclk_ratio_sel #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_sel (
    .div_i       (div_q),
    .slow_i      (slow_q),
    .data_mode_i (data_mode_i),
    .ratio_o     (ratio)
  );

  sdclk_phase_gen #(.RATIO_W(RatioW), .RST_RATIO(RstRatio)) u_gen (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ratio_i  (ratio),
    .sd_clk_o (sd_clk_o),
    .rise_o   (clk_rise_o),
    .fall_o   (clk_fall_o)
  );
endmodule

// File: tb/sd_clk_divider_tb_top.sv
`timescale 1ns/1ps
module sd_clk_divider_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_we = 1'b0, cfg_we = 1'b0, cfg_slow = 1'b0, data_mode = 1'b0;
  logic [10:0] div_wdata = '0;
  logic sd_clk, rise, fall;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  sd_clk_divider dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_we_i(div_we), .div_wdata_i(div_wdata),
    .cfg_we_i(cfg_we), .cfg_slow_i(cfg_slow), .data_mode_i(data_mode),
    .sd_clk_o(sd_clk), .clk_rise_o(rise), .clk_fall_o(fall)
  );

  localparam int NV = 12;
  localparam int V_DIV [NV]  = '{0, 1, 5, 100, 13, 8, 507, 13, 6, 2047, 2047, 2047};
  localparam int V_SLOW[NV]  = '{0, 0, 0, 0,   0,  0, 0,   1,  1, 0,    0,    1};
  localparam int V_DATA[NV]  = '{0, 0, 0, 0,   1,  1, 1,   1,  0, 0,    1,    1};
  localparam int V_PER [NV]  = '{2, 3, 7, 102, 7,  2, 5,   15, 8, 2049, 9,    2049};
  localparam string V_TAG[NV] = '{"R8", "R3", "R2", "R2", "R4", "R4", "R4",
                                   "R5", "R5", "R8", "R4", "R5"};

  task automatic check_eq(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (!rise);
  endtask

  // Starts at a negedge where rise is high; ends on the next such negedge.
  task automatic measure_here(output int per, output int hi, output int nf);
    per = 1; hi = sd_clk ? 1 : 0; nf = 0;
    forever begin
      @(negedge clk);
      if (rise) break;
      per++;
      if (sd_clk) hi++;
      if (fall) nf++;
    end
  endtask

  task automatic apply(int d, int s, int m);
    div_wdata = 11'(d); div_we = 1'b1;
    cfg_slow = s[0]; cfg_we = 1'b1;
    data_mode = m[0];
    @(negedge clk);
    div_we = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1 clk low in reset", int'(sd_clk), 0);
    check_eq("R1 strobes low in reset", int'(rise | fall), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 rise after reset", int'(rise), 1);
    begin
      int p, h, f;
      measure_here(p, h, f);
      check_eq("R1 reset period", p, 509);
      check_eq("R3 reset high phase", h, 255);
    end

    for (int i = 0; i < NV; i++) begin
      int p, h, f;
      wait_rise();
      apply(V_DIV[i], V_SLOW[i], V_DATA[i]);
      wait_rise();
      measure_here(p, h, f);
      check_eq({V_TAG[i], " period"}, p, V_PER[i]);
      check_eq("R3 high phase", h, (V_PER[i] + 1) / 2);
      check_eq("R7 one fall strobe", f, 1);
    end

    // R6: write lands mid-period, old length completes
    begin
      int p, h, f, k;
      apply(20, 0, 0);
      wait_rise();
      measure_here(p, h, f);
      check_eq("R2 period div 20", p, 22);
      apply(0, 0, 0);
      k = 2;
      forever begin
        @(negedge clk);
        if (rise) break;
        k++;
      end
      check_eq("R6 old period kept", k, 22);
      measure_here(p, h, f);
      check_eq("R6 new period", p, 2);
    end

    // R9: mode change at boundary
    begin
      int p, h, f;
      apply(20, 0, 0);
      wait_rise();
      measure_here(p, h, f);
      data_mode = 1'b1;
      measure_here(p, h, f);
      check_eq("R9 old period kept", p, 22);
      measure_here(p, h, f);
      check_eq("R9 data period", p, 6);
      check_eq("R7 fall in data period", f, 1);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule